// File: doc/BRIEF.md
# Interrupt Status and Acknowledge Register

This block is the 16-bit event and state word of a network controller's host interface. Single-cycle event pulses come from the command unit, the receive unit, the management-data interface and software. Each pulse sets a sticky flag in the upper byte. The host acknowledges a flag by writing a 1 to its bit position. The lower byte shows the live state codes of the command and receive units. A registered interrupt line stays high while any flag is set.

The command-unit-not-active flag can run in two modes, chosen by an input. In the first mode it fires whenever the command unit drops out of either queue-active state. In the second mode it fires only when the command unit arrives in idle. The block finds these transitions itself by comparing the current command-unit code with the code from the previous cycle. If a hardware set and a host clear hit the same flag in the same cycle, the set wins, so no event is lost.

Top module: `irq_status_word`

## Requirements
- R1: After reset all flags (bits 15:8) are 0 and `irq` is 0. With both state inputs at zero, `status_word` reads 0x0000.
- R2: A cycle with `clr_wr` high clears every flag whose `clr_data` bit is 1. Flags whose `clr_data` bit is 0 keep their value.
- R3: When a set event and a clearing write reach the same flag in the same cycle, the flag is 1 afterwards.
- R4: Event inputs set their flags one clock after they are sampled: `cmd_done` sets bit 15, `frame_rx_done` sets bit 14, `ru_left_ready` sets bit 12, `sw_irq_req` sets bit 10, `early_rx` sets bit 9 and `fc_pause` sets bit 8.
- R5: `mgmt_cycle_done` sets bit 11 only in a cycle where `mgmt_irq_en` is 1. With `mgmt_irq_en` at 0 it has no effect.
- R6: With `cu_idle_only` at 0, bit 13 sets when the command-unit code changes from an active code (10 or 11) to 00 or 01.
- R7: With `cu_idle_only` at 1, bit 13 sets only when the command-unit code changes from a nonzero value to 00.
- R8: `status_word[7:6]` shows `cu_state` and `status_word[5:2]` shows `ru_state` in the same cycle, including reserved codes. `status_word[1:0]` is always 0.
- R9: `irq` equals the OR of bits 15:8 as they stood one clock earlier. It rises one cycle after the first flag sets and falls one cycle after the last flag clears.
- R10: With no set event and no clearing write, every flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_done | input | 1 | Command with interrupt request finished (bit 15) |
| frame_rx_done | input | 1 | Frame reception finished (bit 14) |
| ru_left_ready | input | 1 | Receive unit left the ready state (bit 12) |
| mgmt_cycle_done | input | 1 | Management read or write cycle finished (bit 11) |
| mgmt_irq_en | input | 1 | Enables the management event |
| sw_irq_req | input | 1 | Software interrupt request (bit 10) |
| early_rx | input | 1 | Early receive event (bit 9) |
| fc_pause | input | 1 | Flow-control pause event (bit 8) |
| cu_state | input | 2 | Command-unit code: 00 idle, 01 suspended, 10 low-priority active, 11 high-priority active |
| ru_state | input | 4 | Receive-unit code |
| cu_idle_only | input | 1 | 0: bit 13 on exit from active; 1: bit 13 on entry to idle |
| clr_wr | input | 1 | Host acknowledge write strobe |
| clr_data | input | 16 | Write-one-to-clear data |
| status_word | output | 16 | Flags, state codes, zero low bits |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default parameters: eight flags, a 2-bit command-unit code and a 4-bit receive-unit code. At these sizes it can cover every case. It tries every ordered pair of command-unit codes in both detector modes, all sixteen receive-unit codes, and every flag through its set, hold, masked write, clear and set-against-clear paths. It also checks the management enable gate and the one-cycle delay of the interrupt line on both edges.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
   localparam int unsigned FLAG_W = 8;
   localparam int unsigned CU_W   = 2;
   localparam int unsigned RU_W   = 4;
   localparam int unsigned RSV_W  = 2;
   localparam int unsigned WORD_W = FLAG_W + CU_W + RU_W + RSV_W;

   typedef enum logic [CU_W-1:0] {
      CU_IDLE  = 2'b00,
      CU_SUSP  = 2'b01,
      CU_LOWQ  = 2'b10,
      CU_HIGHQ = 2'b11
   } cu_code_e;

   // flag positions inside the flag byte
   localparam int unsigned F_CMD   = 7;
   localparam int unsigned F_FRAME = 6;
   localparam int unsigned F_CUNA  = 5;
   localparam int unsigned F_RUNR  = 4;
   localparam int unsigned F_MGMT  = 3;
   localparam int unsigned F_SW    = 2;
   localparam int unsigned F_ERX   = 1;
   localparam int unsigned F_PAUSE = 0;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int unsigned N        = 8,
   parameter bit          SET_WINS = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_vec,
   input  logic [N-1:0] clr_vec,
   output logic [N-1:0] flag_q
);
   if (N < 1) begin : g_bad_n
      $error("irq_flag_bank: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic nxt;
      if (SET_WINS) begin : g_set_pri
         always_comb nxt = set_vec[i] | (flag_q[i] & ~clr_vec[i]);
      end else begin : g_clr_pri
         always_comb nxt = ~clr_vec[i] & (set_vec[i] | flag_q[i]);
      end

      always_ff @(posedge clk) begin
         if (!rst_n) flag_q[i] <= 1'b0;
         else        flag_q[i] <= nxt;
      end

      if (SET_WINS) begin : g_chk_set
         p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> flag_q[i]);
      end
      p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_vec[i] && !set_vec[i]) |=> !flag_q[i]);
      p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr_vec[i] && !set_vec[i]) |=> $stable(flag_q[i]));
   end
endmodule

// File: rtl/cu_exit_detect.sv
module cu_exit_detect
   import irq_status_pkg::*;
#(
   parameter int unsigned W = CU_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cur_state,
   input  logic         idle_only,
   output logic         evt
);
   if (W != CU_W) begin : g_bad_w
      $error("cu_exit_detect: state width must match the package");
   end

   logic [W-1:0] prev_q;
   logic         was_active, is_active, was_idle, is_idle;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= CU_IDLE;
      else        prev_q <= cur_state;
   end

   // both queue-active codes have the top bit set
   always_comb begin
      was_active = prev_q[W-1];
      is_active  = cur_state[W-1];
      was_idle   = (prev_q == CU_IDLE);
      is_idle    = (cur_state == CU_IDLE);
      if (idle_only) evt = is_idle & ~was_idle;
      else           evt = was_active & ~is_active;
   end

   p_idle_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_only && evt) |-> (cur_state == CU_IDLE && prev_q != CU_IDLE));
   p_active_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle_only && evt) |-> (prev_q[W-1] && !cur_state[W-1]));
endmodule

// File: rtl/irq_status_word.sv
module irq_status_word
   import irq_status_pkg::*;
#(
   parameter bit IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_done,
   input  logic              frame_rx_done,
   input  logic              ru_left_ready,
   input  logic              mgmt_cycle_done,
   input  logic              mgmt_irq_en,
   input  logic              sw_irq_req,
   input  logic              early_rx,
   input  logic              fc_pause,
   input  logic [CU_W-1:0]   cu_state,
   input  logic [RU_W-1:0]   ru_state,
   input  logic              cu_idle_only,
   input  logic              clr_wr,
   input  logic [WORD_W-1:0] clr_data,
   output logic [WORD_W-1:0] status_word,
   output logic              irq
);
   if (WORD_W != 16) begin : g_bad_word
      $error("irq_status_word: field widths must total 16 bits");
   end

   logic [FLAG_W-1:0] set_vec, clr_vec, flag_q;
   logic              cu_evt, any_flag;

   cu_exit_detect #(.W(CU_W)) u_cu_det (
      .clk       (clk),
      .rst_n     (rst_n),
      .cur_state (cu_state),
      .idle_only (cu_idle_only),
      .evt       (cu_evt)
   );

   always_comb begin
      set_vec          = '0;
      set_vec[F_CMD]   = cmd_done;
      set_vec[F_FRAME] = frame_rx_done;
      set_vec[F_CUNA]  = cu_evt;
      set_vec[F_RUNR]  = ru_left_ready;
      set_vec[F_MGMT]  = mgmt_cycle_done & mgmt_irq_en;
      set_vec[F_SW]    = sw_irq_req;
      set_vec[F_ERX]   = early_rx;
      set_vec[F_PAUSE] = fc_pause;
      clr_vec = clr_wr ? clr_data[WORD_W-1 -: FLAG_W] : '0;
   end

   irq_flag_bank #(.N(FLAG_W), .SET_WINS(1'b1)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (set_vec),
      .clr_vec (clr_vec),
      .flag_q  (flag_q)
   );

   assign status_word = {flag_q, cu_state, ru_state, {RSV_W{1'b0}}};
   assign any_flag    = |flag_q;

   if (IRQ_REG) begin : g_irq_ff
      always_ff @(posedge clk) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= any_flag;
      end
      p_irq_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
         any_flag |=> irq);
      p_irq_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
         !any_flag |=> !irq);
   end else begin : g_irq_comb
      assign irq = any_flag;
   end

   p_mgmt_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!mgmt_irq_en && !flag_q[F_MGMT]) |=> !flag_q[F_MGMT]);
   p_low_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      status_word[RSV_W-1:0] == '0);
endmodule

// File: tb/irq_status_word_tb.sv
module irq_status_word_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_done = 0, frame_rx_done = 0, ru_left_ready = 0, mgmt_cycle_done = 0;
   logic        mgmt_irq_en = 1, sw_irq_req = 0, early_rx = 0, fc_pause = 0;
   logic [1:0]  cu_state = 2'b00;
   logic [3:0]  ru_state = 4'h0;
   logic        cu_idle_only = 0, clr_wr = 0;
   logic [15:0] clr_data = 16'h0;
   logic [15:0] status_word;
   logic        irq;
   int          n_chk = 0, n_err = 0;

   always #4 clk = ~clk;

   irq_status_word u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_done(cmd_done), .frame_rx_done(frame_rx_done),
      .ru_left_ready(ru_left_ready), .mgmt_cycle_done(mgmt_cycle_done),
      .mgmt_irq_en(mgmt_irq_en), .sw_irq_req(sw_irq_req), .early_rx(early_rx),
      .fc_pause(fc_pause), .cu_state(cu_state), .ru_state(ru_state),
      .cu_idle_only(cu_idle_only), .clr_wr(clr_wr), .clr_data(clr_data),
      .status_word(status_word), .irq(irq)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic drive_evt(input int bitpos, input logic v);
      case (bitpos)
         15: cmd_done = v;
         14: frame_rx_done = v;
         12: ru_left_ready = v;
         11: mgmt_cycle_done = v;
         10: sw_irq_req = v;
         9:  early_rx = v;
         8:  fc_pause = v;
         default: ;
      endcase
   endtask

   task automatic clear_all();
      clr_wr = 1; clr_data = 16'hFFFF; tick();
      clr_wr = 0; clr_data = 16'h0; tick();
   endtask

   initial begin
      #1_000_000;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      tick(); tick();
      // R1 reset state
      check("R1 status", status_word, 16'h0000);
      check("R1 irq", {15'h0, irq}, 16'h0);
      rst_n = 1; tick();
      check("R1 after release", status_word, 16'h0000);

      // R4/R5 per flag: set, irq rise, hold, masked write, clear, irq fall
      for (int b = 8; b < 16; b++) begin
         if (b == 13) continue;
         clear_all();
         drive_evt(b, 1); tick(); drive_evt(b, 0);
         check(b == 11 ? "R5 mgmt set" : "R4 set", status_word & 16'hFF00, 16'(1) << b);
         tick();
         check("R9 irq rise", {15'h0, irq}, 16'h1);
         check("R10 hold", status_word & 16'hFF00, 16'(1) << b);
         clr_wr = 1; clr_data = ~(16'(1) << b); tick();
         check("R2 zero keeps", status_word & 16'hFF00, 16'(1) << b);
         clr_data = 16'(1) << b; tick(); clr_wr = 0; clr_data = 0;
         check("R2 one clears", status_word & 16'hFF00, 16'h0);
         check("R9 irq one late", {15'h0, irq}, 16'h1);
         tick();
         check("R9 irq fall", {15'h0, irq}, 16'h0);
      end

      // R5 gating
      clear_all();
      mgmt_irq_en = 0; mgmt_cycle_done = 1; tick(); mgmt_cycle_done = 0; mgmt_irq_en = 1;
      check("R5 gated", status_word & 16'hFF00, 16'h0);
      tick();
      check("R5 gated irq", {15'h0, irq}, 16'h0);

      // R3 set against clear
      for (int b = 8; b < 16; b++) begin
         if (b == 13) continue;
         clear_all();
         drive_evt(b, 1); clr_wr = 1; clr_data = 16'hFFFF; tick();
         drive_evt(b, 0); clr_wr = 0; clr_data = 0;
         check("R3 set wins", status_word & 16'hFF00, 16'(1) << b);
      end
      clear_all();

      // R8 live fields
      for (int c = 0; c < 4; c++)
         for (int r = 0; r < 16; r++) begin
            cu_state = 2'(c); ru_state = 4'(r); #1;
            check("R8 fields", status_word & 16'h00FF, {8'h0, 2'(c), 4'(r), 2'b00});
         end
      ru_state = 0; cu_state = 0; tick(); tick(); clear_all();

      // R6/R7 every transition pair in both modes
      for (int m = 0; m < 2; m++)
         for (int p = 0; p < 4; p++)
            for (int c = 0; c < 4; c++) begin
               logic exp13;
               cu_idle_only = m[0];
               cu_state = 2'(p); clr_wr = 1; clr_data = 16'hFFFF; tick(); tick();
               clr_wr = 0; clr_data = 0;
               cu_state = 2'(c); tick();
               if (m == 0) exp13 = (p >= 2) && (c < 2);
               else        exp13 = (p != 0) && (c == 0);
               check(m == 0 ? "R6 exit active" : "R7 enter idle",
                     {15'h0, status_word[13]}, {15'h0, exp13});
            end

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule